// File: doc/BRIEF.md
# Tower-Field AES Substitution Box

This block is the forward-direction byte substitution of AES, built without a lookup table. An input byte is first moved by a fixed bit matrix into a nested field representation. In that representation GF(2^8) is a quadratic extension of GF(2^4), and GF(2^4) is in turn a quadratic extension of GF(2^2). Every level uses a normal basis: each element is written over a pair of conjugate elements.

The multiplicative inverse is formed in that representation. The work reduces to a few GF(2^4) products and a single GF(2^4) inverse. The GF(2^4) inverse reduces again to GF(2^2) products plus a bit swap. A second bit matrix maps the inverse back to the standard representation, GF(2)[x]/(x^8+x^4+x^3+x+1). The AES affine step is folded into that second matrix, followed by an XOR with the constant 0x63.

The block is purely combinational and has no clock or reset. It is meant to be instanced wherever a round datapath or key expansion needs a substitution. Both basis matrices and the extension constants are derived at elaboration time from the chosen subfield constants. Any valid choice of those constants therefore yields a correct isomorphism.

Top module: `aes_sbox_tower`

## Requirements
- R1: For every input byte x, `sub_out` equals A(x^-1) XOR 0x63. Here x^-1 is the inverse of x in GF(2)[x]/(x^8+x^4+x^3+x+1), with 0 taken as its own inverse. A is the linear map whose output bit i is the XOR of input bits i, i+4, i+5, i+6 and i+7, indices taken mod 8.
- R2: Input 0x00 gives output 0x63.
- R3: Input 0x53 gives output 0xED.
- R4: The output depends only on the present input and holds no state. A new input applied at one clock edge is reflected correctly before the following opposite edge, even when the input changes on every cycle.
- R5: The mapping is a permutation: the 256 inputs produce 256 distinct outputs. In particular, 0x63 appears only for input 0x00.
- R6: No input maps to itself, and no input maps to its bitwise complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sub_in | input | 8 | Byte to substitute, standard polynomial representation |
| sub_out | output | 8 | Substituted byte, standard polynomial representation |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between `sub_in` and `sub_out`. The bench changes the input just after a rising edge and reads the output at the next falling edge, half a period later, so that every path has settled. Back-to-back sweeps change the input on every cycle, which shows that no earlier value leaks into a later result. The internal checks on the tower-field inverse and on the forward map are evaluated whenever the combinational values change.

// File: rtl/aes_tower_pkg.sv
// Package: arithmetic over the normal-basis tower GF(((2^2)^2)^2) and the
// constants derived from it at elaboration.
// Encoding assumed everywhere:
//   GF(4):   {g1,g0} = g1*W + g0*W^2, with W^2 + W + 1 = 0 (so one = 2'b11)
//   GF(16):  {hi,lo} = hi*Ybar + lo*Y, with Y + Ybar = 1 and Y*Ybar = NU4
//   GF(256): {hi,lo} = hi*Zbar + lo*Z, with Z + Zbar = 1 and Z*Zbar = MU16
package aes_tower_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int DIB_W  = 2;

    typedef logic [DIB_W-1:0]  gf4_t;
    typedef logic [NIB_W-1:0]  gf16_t;
    typedef logic [BYTE_W-1:0] gf256_t;
    typedef logic [BYTE_W-1:0][BYTE_W-1:0] bmat_t;

    // Norm constant of the GF(16) extension: W, whose GF(4)/GF(2) trace is one
    localparam gf4_t   NU4       = 2'b10;
    localparam gf16_t  GF16_ONE  = 4'hF;
    localparam gf256_t GF256_ONE = 8'hFF;
    localparam gf256_t AFF_CONST = 8'h63;

    // Product in GF(4), normal basis
    function automatic gf4_t gf4_mul(input gf4_t a, input gf4_t b);
        logic t;
        t = (a[1] ^ a[0]) & (b[1] ^ b[0]);
        return {(a[1] & b[1]) ^ t, (a[0] & b[0]) ^ t};
    endfunction

    // Product in GF(16), normal basis over GF(4)
    function automatic gf16_t gf16_mul(input gf16_t a, input gf16_t b);
        gf4_t ph, pl, e;
        ph = gf4_mul(a[3:2], b[3:2]);
        pl = gf4_mul(a[1:0], b[1:0]);
        e  = gf4_mul(gf4_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]), NU4);
        return {ph ^ e, pl ^ e};
    endfunction

    // Absolute trace GF(16) -> GF(2), result is 0 or GF16_ONE
    function automatic gf16_t gf16_trace(input gf16_t x);
        gf16_t x2, x4, x8;
        x2 = gf16_mul(x, x);
        x4 = gf16_mul(x2, x2);
        x8 = gf16_mul(x4, x4);
        return x ^ x2 ^ x4 ^ x8;
    endfunction

    // First GF(16) element of trace one: makes z^2 + z + mu irreducible
    function automatic gf16_t pick_mu();
        gf16_t m;
        logic  found;
        m = '0;
        found = 1'b0;
        for (int c = 1; c < 16; c++) begin
            if (!found && gf16_trace(gf16_t'(c)) == GF16_ONE) begin
                m = gf16_t'(c);
                found = 1'b1;
            end
        end
        return m;
    endfunction

    localparam gf16_t MU16 = pick_mu();

    // Product in GF(256), normal basis over GF(16)
    function automatic gf256_t gf256_mul(input gf256_t a, input gf256_t b);
        gf16_t ph, pl, e;
        ph = gf16_mul(a[7:4], b[7:4]);
        pl = gf16_mul(a[3:0], b[3:0]);
        e  = gf16_mul(gf16_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]), MU16);
        return {ph ^ e, pl ^ e};
    endfunction

    // Tower element that is a root of x^8 + x^4 + x^3 + x + 1
    function automatic gf256_t find_root();
        gf256_t r, p1, p2, p3, p4, p8;
        logic   found;
        r = '0;
        found = 1'b0;
        for (int c = 1; c < 256; c++) begin
            p1 = gf256_t'(c);
            p2 = gf256_mul(p1, p1);
            p3 = gf256_mul(p2, p1);
            p4 = gf256_mul(p2, p2);
            p8 = gf256_mul(p4, p4);
            if (!found && (p8 ^ p4 ^ p3 ^ p1 ^ GF256_ONE) == '0) begin
                r = p1;
                found = 1'b1;
            end
        end
        return r;
    endfunction

    localparam gf256_t ROOT = find_root();

    // Columns of standard->tower matrix: column k is ROOT^k
    function automatic bmat_t fwd_cols();
        bmat_t  m;
        gf256_t p;
        p = GF256_ONE;
        for (int k = 0; k < BYTE_W; k++) begin
            m[k] = p;
            p = gf256_mul(p, ROOT);
        end
        return m;
    endfunction

    localparam bmat_t FWD_COLS = fwd_cols();

    // Apply a column matrix to a byte
    function automatic gf256_t apply_cols(input bmat_t m, input gf256_t v);
        gf256_t acc;
        acc = '0;
        for (int k = 0; k < BYTE_W; k++)
            if (v[k]) acc ^= m[k];
        return acc;
    endfunction

    // Linear part of the AES affine step
    function automatic gf256_t aff_lin(input gf256_t b);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]};
    endfunction

    // Columns of tower->standard matrix with the affine step folded in
    function automatic bmat_t out_cols();
        bmat_t m;
        m = '0;
        for (int j = 0; j < BYTE_W; j++)
            for (int a = 0; a < 256; a++)
                if (apply_cols(FWD_COLS, gf256_t'(a)) == (gf256_t'(1) << j))
                    m[j] = aff_lin(gf256_t'(a));
        return m;
    endfunction

    localparam bmat_t OUT_COLS = out_cols();

endpackage

// File: rtl/gf_basis_map.sv
// Module: constant bit-matrix change of basis plus constant XOR.
// Assumes COLS[k] is the image of input bit k; synthesis shares the common
// XOR terms of the rows since the matrix is a constant.
module gf_basis_map #(
    parameter int W = 8,
    parameter logic [W-1:0][W-1:0] COLS = '0,
    parameter logic [W-1:0] OFFSET = '0
) (
    input  logic [W-1:0] vin,
    output logic [W-1:0] vout
);
    genvar j, k;
    generate
        for (j = 0; j < W; j++) begin : g_row
            logic [W-1:0] row;
            for (k = 0; k < W; k++) begin : g_col
                assign row[k] = COLS[k][j];
            end
            // One output bit: parity of the selected input bits
            assign vout[j] = OFFSET[j] ^ (^(vin & row));
        end
    endgenerate
endmodule

// File: rtl/gf16_nb_inv.sv
// Module: inverse in GF(16) over a GF(4) normal basis.
// Assumes encoding of aes_tower_pkg; zero maps to zero.
module gf16_nb_inv
    import aes_tower_pkg::*;
(
    input  gf16_t x,
    output gf16_t y
);
    gf4_t hi, lo, sum_sq, nrm, nrm_inv;

    // Norm in GF(4), its inverse (a swap), then scale the conjugate
    always_comb begin
        hi      = x[3:2];
        lo      = x[1:0];
        sum_sq  = {lo[1] ^ hi[1], lo[0] ^ hi[0]};
        sum_sq  = {sum_sq[0], sum_sq[1]};
        nrm     = gf4_mul(hi, lo) ^ gf4_mul(sum_sq, NU4);
        nrm_inv = {nrm[0], nrm[1]};
        y       = {gf4_mul(lo, nrm_inv), gf4_mul(hi, nrm_inv)};
    end
endmodule

// File: rtl/gf256_nb_inv.sv
// Module: inverse in GF(256) over a GF(16) normal basis.
// Assumes encoding of aes_tower_pkg; zero maps to zero.
module gf256_nb_inv
    import aes_tower_pkg::*;
(
    input  gf256_t x,
    output gf256_t y
);
    gf16_t hi, lo, sum, nrm, nrm_inv;

    // Norm of x down to GF(16)
    always_comb begin
        hi  = x[7:4];
        lo  = x[3:0];
        sum = hi ^ lo;
        nrm = gf16_mul(hi, lo) ^ gf16_mul(gf16_mul(sum, sum), MU16);
    end

    gf16_nb_inv u_sub_inv (
        .x(nrm),
        .y(nrm_inv)
    );

    // Scale the conjugate by the inverted norm
    always_comb y = {gf16_mul(lo, nrm_inv), gf16_mul(hi, nrm_inv)};
endmodule

// File: rtl/aes_sbox_tower.sv
// Module: forward AES substitution, combinational, tower-field inversion.
// Assumes standard byte encoding on both ports; no clock, no state.
module aes_sbox_tower
    import aes_tower_pkg::*;
(
    input  logic [7:0] sub_in,
    output logic [7:0] sub_out
);
    gf256_t tw_fwd, tw_inv;

    gf_basis_map #(.W(BYTE_W), .COLS(FWD_COLS), .OFFSET('0)) u_to_tower (
        .vin (sub_in),
        .vout(tw_fwd)
    );

    gf256_nb_inv u_inv (
        .x(tw_fwd),
        .y(tw_inv)
    );

    gf_basis_map #(.W(BYTE_W), .COLS(OUT_COLS), .OFFSET(AFF_CONST)) u_from_tower (
        .vin (tw_inv),
        .vout(sub_out)
    );
endmodule

// File: rtl/aes_sbox_tower_chk.sv
// Checker: combinational properties of the substitution and its tower core.
module aes_sbox_tower_chk
    import aes_tower_pkg::*;
(
    input logic [7:0] din,
    input logic [7:0] dout,
    input gf256_t     tw,
    input gf256_t     twi
);
    // Evaluate on every settled change of the observed values
    always_comb begin
        p_zero_in_r2: assert (din != 8'h00 || dout == 8'h63)
            else $error("zero input did not give 0x63");
        p_known_r3: assert (din != 8'h53 || dout == 8'hED)
            else $error("0x53 did not give 0xED");
        p_only_zero_r5: assert (dout != 8'h63 || din == 8'h00)
            else $error("0x63 produced for nonzero input");
        p_fwd_zero_r1: assert ((tw == '0) == (din == 8'h00))
            else $error("forward map zero mismatch");
        p_tower_inv_r1: assert ((tw == '0) ? (twi == '0) : (gf256_mul(tw, twi) == GF256_ONE))
            else $error("tower inverse wrong");
    end
endmodule

bind aes_sbox_tower aes_sbox_tower_chk u_chk (
    .din (sub_in),
    .dout(sub_out),
    .tw  (tw_fwd),
    .twi (tw_inv)
);

// File: tb/aes_sbox_tower_test.sv
// Bench: directed tasks against a brute-force reference substitution.
module aes_sbox_tower_test;
    logic       clk = 1'b0;
    logic [7:0] sub_in = 8'h00;
    logic [7:0] sub_out;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    aes_sbox_tower uut (
        .sub_in (sub_in),
        .sub_out(sub_out)
    );

    // Polynomial product modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
        end
        return p;
    endfunction

    // Reference substitution: search for the inverse, then the affine step
    function automatic logic [7:0] ref_sub(input logic [7:0] a);
        logic [7:0] inv = 8'h00;
        logic [7:0] r;
        for (int c = 1; c < 256; c++)
            if (ref_mul(a, 8'(c)) == 8'h01) inv = 8'(c);
        for (int i = 0; i < 8; i++)
            r[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8] ^ inv[(i + 6) % 8] ^ inv[(i + 7) % 8];
        return r ^ 8'h63;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: in=%h got=%h expected=%h", tag, sub_in, got, exp);
        end
    endtask

    // Drive just after a rising edge, read at the next falling edge
    task automatic apply(input logic [7:0] v);
        @(posedge clk);
        sub_in <= v;
        @(negedge clk);
    endtask

    task automatic t_zero_r2();
        apply(8'h00);
        check("R2", sub_out, 8'h63);
    endtask

    task automatic t_known_r3();
        apply(8'h53);
        check("R3", sub_out, 8'hED);
        apply(8'h01);
        check("R1", sub_out, 8'h7C);
        apply(8'hFF);
        check("R1", sub_out, 8'h16);
        apply(8'h10);
        check("R1", sub_out, 8'hCA);
    endtask

    // Every input, one per cycle: also covers the stateless behaviour of R4
    task automatic t_sweep_r1_r4();
        for (int v = 0; v < 256; v++) begin
            apply(8'(v));
            check("R1", sub_out, ref_sub(8'(v)));
        end
        for (int v = 255; v >= 0; v -= 7) begin
            apply(8'(v));
            check("R4", sub_out, ref_sub(8'(v)));
        end
    endtask

    task automatic t_perm_r5_r6();
        logic [255:0] seen = '0;
        int dup = 0;
        int fix = 0;
        for (int v = 0; v < 256; v++) begin
            apply(8'(v));
            if (seen[sub_out]) dup++;
            seen[sub_out] = 1'b1;
            if (sub_out == 8'(v) || sub_out == ~8'(v)) fix++;
        end
        n_chk++;
        if (dup != 0) begin
            n_bad++;
            $display("FAIL R5: duplicates=%0d expected=0", dup);
        end
        n_chk++;
        if (fix != 0) begin
            n_bad++;
            $display("FAIL R6: fixed or complement points=%0d expected=0", fix);
        end
    endtask

    initial begin
        t_zero_r2();
        t_known_r3();
        t_sweep_r1_r4();
        t_perm_r5_r6();
        done = 1'b1;
    end

    // Watchdog, then the summary line
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL watchdog: got=timeout expected=completion");
                end
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule